// File: doc/BRIEF.md
# Virtual Processor Suspend/Resume Controller

This block coordinates a fixed set of virtual processors (VPs) that share one core. Each VP owns a one-bit suspend-others flag, which software sees as bit 0 of a control word, and a read-only identity word that holds the VP's index. The block watches every VP's issue slot for the two suspend and resume instructions. When a VP suspends the others, every other VP is put to sleep and the issuer keeps running. When it resumes them, the block wakes every other VP except the ones that are parked in a wait-for-interrupt state. In both cases the issuer gets back its control word from before the instruction, written to the destination register named in the instruction, one cycle later.

The block also computes, for each VP, whether it is currently allowed to run and whether a pending wake request counts as work. A VP that has been suspended by a peer cannot see its wake requests. When several VPs issue a suspend or resume instruction in the same cycle, the lowest-indexed one is served and the others are told to stall and hold their instruction. A global enable input stands for the feature-present configuration bit. When it is low, the instructions do nothing and the activity gating is bypassed.

A coprocessor read port returns either VP's control word or identity word. The matching write port exists, but anything written through it is discarded.

Top module: `vp_run_ctrl`

## Requirements
- R1: An issue word is a suspend instruction when (word & 32'hFFE0FFFF) == 32'h41600024, and a resume instruction when the same mask gives 32'h41600004. Bits 20:16 name the destination register. Any other word causes no writeback, no stall and no state change.
- R2: A suspend from VP k with its flag clear sets VP k's flag and puts every other VP to sleep. From the next cycle, run_en is low for every VP except k.
- R3: A suspend from VP k with its flag already set changes no flag and no sleep state.
- R4: A resume from VP k with its flag set clears that flag and wakes every other VP whose wfi_halt is low in that cycle. A VP with wfi_halt high stays asleep, and its run_en stays low even after wfi_halt falls, until it has work.
- R5: A resume from VP k with its flag clear changes no flag and no sleep state.
- R6: The cycle after an instruction is accepted, wb_vld of the issuer is high for one cycle, wb_idx carries bits 20:16 of the word, and wb_data is the issuer's control word before the instruction: zero in bits 31:1 and the flag in bit 0.
- R7: vp_active of VP i is high when VP i's flag is set, or when no other VP's flag is set. Otherwise it is low.
- R8: has_work of VP i equals wake_req AND vp_active. A sleeping VP leaves sleep in the cycle after it has work. run_en is high exactly when the VP is neither asleep nor wfi_halt.
- R9: Among VPs issuing suspend or resume in one cycle, only the lowest index is accepted. issue_stall is high for each other such VP, and no writeback follows for them.
- R10: When feature_en is low, suspend and resume cause no stall, no writeback and no state change, every VP is active, and has_work follows wake_req.
- R11: A read with cop_rd_sel 0 returns the selected VP's control word (flag in bit 0). cop_rd_sel 1 returns the VP index in bits 7:0 with zeros above, and any other select returns zero. Writes through the cop_wr port change neither word.
- R12: After reset every flag is clear, no VP is asleep, and no writeback is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feature_en | input | 1 | Virtual-processor feature present |
| ins_vld | input | NUM_VP | Per-VP issue strobe |
| ins_word | input | NUM_VP x 32 | Per-VP instruction word |
| wfi_halt | input | NUM_VP | VP is parked in wait-for-interrupt |
| wake_req | input | NUM_VP | Pending wake request per VP |
| issue_stall | output | NUM_VP | Instruction not accepted this cycle, hold it |
| run_en | output | NUM_VP | VP may run |
| vp_active | output | NUM_VP | VP not suspended by a peer |
| has_work | output | NUM_VP | Wake request that counts |
| wb_vld | output | NUM_VP | Register writeback strobe |
| wb_idx | output | NUM_VP x 5 | Destination register index |
| wb_data | output | NUM_VP x 32 | Prior control word |
| cop_rd_vp | input | IDX_W | VP selected for read |
| cop_rd_sel | input | 3 | 0 control, 1 identity |
| cop_rd_data | output | 32 | Read data |
| cop_wr_en | input | 1 | Write strobe (discarded) |
| cop_wr_vp | input | IDX_W | VP selected for write |
| cop_wr_sel | input | 3 | Word selected for write |
| cop_wr_data | input | 32 | Write data |

## Verification
The assertions assume that a VP told to stall keeps presenting its instruction, or drops it only after it has been put to sleep. They also assume that cop_rd_vp and cop_wr_vp are below NUM_VP, and that nothing but clk and rst_n changes near a clock edge. The stimulus drives every input on the falling edge. It uses only in-range VP indices, and when a stalled VP is suspended by the VP that won arbitration, the stimulus withdraws the stalled request, because a sleeping VP issues nothing. Same-cycle contention, resume over a mix of parked and running VPs, and disabled-feature operation are each driven on purpose, and a behavioural model checks every output on every cycle.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam logic [31:0] VPC_OP_MASK   = 32'hFFE0FFFF;
  localparam logic [31:0] VPC_SUSP_CODE = 32'h41600024;
  localparam logic [31:0] VPC_RESM_CODE = 32'h41600004;
  localparam int          VPC_RT_LSB    = 16;
  localparam int          VPC_RT_W      = 5;
  localparam int          VPC_ID_W      = 8;
  localparam int          VPC_SEL_W     = 3;

  typedef enum logic [1:0] {
    VPC_NONE = 2'd0,
    VPC_SUSP = 2'd1,
    VPC_RESM = 2'd2
  } vpc_op_e;

  typedef struct packed {
    vpc_op_e               op;
    logic [VPC_RT_W-1:0]   rt;
  } vpc_req_t;

  function automatic vpc_req_t vpc_classify(input logic [31:0] w);
    vpc_req_t r;
    r.rt = w[VPC_RT_LSB +: VPC_RT_W];
    if ((w & VPC_OP_MASK) == VPC_SUSP_CODE)      r.op = VPC_SUSP;
    else if ((w & VPC_OP_MASK) == VPC_RESM_CODE) r.op = VPC_RESM;
    else                                         r.op = VPC_NONE;
    return r;
  endfunction
endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
  import vpc_pkg::*;
#(
  parameter int NUM_VP = 4
) (
  input  logic                    feature_en,
  input  logic [NUM_VP-1:0]       ins_vld,
  input  logic [NUM_VP-1:0][31:0] ins_word,
  output vpc_req_t [NUM_VP-1:0]   req_o,
  output logic [NUM_VP-1:0]       want_o
);
  for (genvar i = 0; i < NUM_VP; i++) begin : g_dec
    always_comb begin
      req_o[i]  = vpc_classify(ins_word[i]);
      want_o[i] = feature_en && ins_vld[i] && (req_o[i].op != VPC_NONE);
    end
  end
endmodule

// File: rtl/vpc_arbiter.sv
module vpc_arbiter #(
  parameter int NUM_VP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VP-1:0] want,
  output logic [NUM_VP-1:0] grant,
  output logic [NUM_VP-1:0] stall
);
  // isolate lowest set bit: lowest VP index wins
  always_comb begin
    grant = want & (~want + NUM_VP'(1));
    stall = want & ~grant;
  end

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r9_someone_served: assert property (@(posedge clk) disable iff (!rst_n)
    (|want) |-> ($countones(grant) == 1 && (grant & want) == grant));
endmodule

// File: rtl/vpc_status.sv
module vpc_status #(
  parameter int NUM_VP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feature_en,
  input  logic [NUM_VP-1:0] dis_q,
  input  logic [NUM_VP-1:0] wake_req,
  output logic [NUM_VP-1:0] active,
  output logic [NUM_VP-1:0] has_work
);
  for (genvar i = 0; i < NUM_VP; i++) begin : g_st
    logic peer_dis;
    always_comb begin
      peer_dis    = |(dis_q & ~(NUM_VP'(1) << i));
      active[i]   = !feature_en || dis_q[i] || !peer_dis;
      has_work[i] = wake_req[i] && active[i];
    end

    a_r8_idle_hides_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (feature_en && !dis_q[i] && peer_dis) |-> !has_work[i]);
    a_r7_owner_active: assert property (@(posedge clk) disable iff (!rst_n)
      dis_q[i] |-> active[i]);
  end
endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
  import vpc_pkg::*;
#(
  parameter int NUM_VP = 4,
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             feature_en,
  input  logic [NUM_VP-1:0]                ins_vld,
  input  logic [NUM_VP-1:0][31:0]          ins_word,
  input  logic [NUM_VP-1:0]                wfi_halt,
  input  logic [NUM_VP-1:0]                wake_req,
  output logic [NUM_VP-1:0]                issue_stall,
  output logic [NUM_VP-1:0]                run_en,
  output logic [NUM_VP-1:0]                vp_active,
  output logic [NUM_VP-1:0]                has_work,
  output logic [NUM_VP-1:0]                wb_vld,
  output logic [NUM_VP-1:0][VPC_RT_W-1:0]  wb_idx,
  output logic [NUM_VP-1:0][31:0]          wb_data,
  input  logic [IDX_W-1:0]                 cop_rd_vp,
  input  logic [VPC_SEL_W-1:0]             cop_rd_sel,
  output logic [31:0]                      cop_rd_data,
  input  logic                             cop_wr_en,
  input  logic [IDX_W-1:0]                 cop_wr_vp,
  input  logic [VPC_SEL_W-1:0]             cop_wr_sel,
  input  logic [31:0]                      cop_wr_data
);
  vpc_req_t [NUM_VP-1:0] req;
  logic [NUM_VP-1:0] want, grant;

  logic [NUM_VP-1:0] dis_q, dis_d;
  logic [NUM_VP-1:0] sleep_q, sleep_d;
  logic [NUM_VP-1:0] wbv_q, wbv_d;
  logic [NUM_VP-1:0] wbbit_q, wbbit_d;
  logic [NUM_VP-1:0][VPC_RT_W-1:0] wbidx_q, wbidx_d;

  vpc_op_e            sel_op;
  logic [VPC_RT_W-1:0] sel_rt;
  logic               fire, prior;

  vpc_decode #(.NUM_VP(NUM_VP)) u_dec (
    .feature_en (feature_en), .ins_vld(ins_vld), .ins_word(ins_word),
    .req_o(req), .want_o(want)
  );

  vpc_arbiter #(.NUM_VP(NUM_VP)) u_arb (
    .clk(clk), .rst_n(rst_n), .want(want), .grant(grant), .stall(issue_stall)
  );

  vpc_status #(.NUM_VP(NUM_VP)) u_st (
    .clk(clk), .rst_n(rst_n), .feature_en(feature_en), .dis_q(dis_q),
    .wake_req(wake_req), .active(vp_active), .has_work(has_work)
  );

  // one-hot mux of the served request
  always_comb begin
    sel_op = VPC_NONE;
    sel_rt = '0;
    for (int i = 0; i < NUM_VP; i++) begin
      if (grant[i]) begin
        sel_op = req[i].op;
        sel_rt = req[i].rt;
      end
    end
    fire  = |grant;
    prior = |(dis_q & grant);
  end

  // next state
  always_comb begin
    dis_d   = dis_q;
    sleep_d = sleep_q & ~has_work;
    wbv_d   = grant;
    wbbit_d = wbbit_q;
    wbidx_d = wbidx_q;
    if (fire) begin
      for (int i = 0; i < NUM_VP; i++) begin
        if (grant[i]) begin
          wbbit_d[i] = prior;
          wbidx_d[i] = sel_rt;
        end
      end
      if (sel_op == VPC_SUSP && !prior) begin
        dis_d   = dis_q | grant;
        sleep_d = sleep_d | ~grant;
      end else if (sel_op == VPC_RESM && prior) begin
        dis_d   = dis_q & ~grant;
        sleep_d = sleep_d & (grant | wfi_halt);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= '0;
      sleep_q <= '0;
      wbv_q   <= '0;
      wbbit_q <= '0;
      wbidx_q <= '0;
    end else begin
      dis_q   <= dis_d;
      sleep_q <= sleep_d;
      wbv_q   <= wbv_d;
      if (fire) begin
        wbbit_q <= wbbit_d;
        wbidx_q <= wbidx_d;
      end
    end
  end

  // outputs
  always_comb begin
    run_en = ~sleep_q & ~wfi_halt;
    wb_vld = wbv_q;
    wb_idx = wbidx_q;
    for (int i = 0; i < NUM_VP; i++) wb_data[i] = {31'd0, wbbit_q[i]};
    cop_rd_data = '0;
    if (cop_rd_sel == VPC_SEL_W'(0) && 32'(cop_rd_vp) < NUM_VP)
      cop_rd_data = {31'd0, dis_q[cop_rd_vp]};
    else if (cop_rd_sel == VPC_SEL_W'(1))
      cop_rd_data = {{(32-VPC_ID_W){1'b0}}, VPC_ID_W'(cop_rd_vp)};
  end

  for (genvar i = 0; i < NUM_VP; i++) begin : g_chk
    a_r2_susp_halts_peers: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && sel_op == VPC_SUSP && !dis_q[i]) |=>
        (dis_q[i] && (&(sleep_q | (NUM_VP'(1) << i)))));
    a_r3_susp_repeat_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && sel_op == VPC_SUSP && dis_q[i]) |=> $stable(dis_q));
    a_r4_resm_spares_wfi: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && sel_op == VPC_RESM && dis_q[i]) |=>
        (!dis_q[i] && ((sleep_q & $past(wfi_halt & ~grant & ~has_work)) ==
                       $past(sleep_q & wfi_halt & ~grant & ~has_work))));
    a_r6_wb_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld[i] |-> $past(grant[i] && feature_en));
  end

  a_r10_off_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !feature_en |=> (wb_vld == '0));
  a_r11_write_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_wr_en && cop_wr_sel == VPC_SEL_W'(0) && !fire &&
     cop_wr_data[0] != dis_q[cop_wr_vp]) |=> $stable(dis_q));
endmodule

// File: tb/tb_vp_run_ctrl.sv
`timescale 1ns/100ps
module tb_vp_run_ctrl;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic feature_en;
  logic [N-1:0] ins_vld, wfi_halt, wake_req;
  logic [N-1:0][31:0] ins_word;
  logic [N-1:0] issue_stall, run_en, vp_active, has_work, wb_vld;
  logic [N-1:0][4:0] wb_idx;
  logic [N-1:0][31:0] wb_data;
  logic [IW-1:0] cop_rd_vp, cop_wr_vp;
  logic [2:0] cop_rd_sel, cop_wr_sel;
  logic [31:0] cop_rd_data, cop_wr_data;
  logic cop_wr_en;

  always #2.5 clk = ~clk;

  vp_run_ctrl #(.NUM_VP(N)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit m_dis[N], m_sleep[N];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] susp_w(input int rt);
    return 32'h41600024 | (32'(rt) << 16);
  endfunction
  function automatic logic [31:0] resm_w(input int rt);
    return 32'h41600004 | (32'(rt) << 16);
  endfunction

  // one clock of the reference model; inputs already applied
  task automatic step(input string tag);
    int g = -1;
    bit is_s, is_r, prior;
    logic [N-1:0] e_stall = '0, e_act = '0, e_hw = '0, e_run = '0, e_wbv = '0;
    logic [31:0] e_rd;
    bit n_dis[N], n_slp[N];
    int rt = 0;
    #1;
    for (int i = 0; i < N; i++) begin
      bit s = (ins_word[i] & 32'hFFE0FFFF) == 32'h41600024;
      bit r = (ins_word[i] & 32'hFFE0FFFF) == 32'h41600004;
      if (feature_en && ins_vld[i] && (s || r)) begin
        if (g < 0) begin g = i; is_s = s; is_r = r; rt = int'(ins_word[i][20:16]); end
        else e_stall[i] = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      bit other = 0;
      for (int j = 0; j < N; j++) if (j != i && m_dis[j]) other = 1;
      e_act[i] = !feature_en || m_dis[i] || !other;
      e_hw[i]  = wake_req[i] && e_act[i];
      e_run[i] = !m_sleep[i] && !wfi_halt[i];
    end
    if (cop_rd_sel == 0)      e_rd = {31'd0, m_dis[cop_rd_vp]};
    else if (cop_rd_sel == 1) e_rd = 32'(cop_rd_vp);
    else                      e_rd = 0;
    chk({tag, " R9 stall"}, 32'(issue_stall), 32'(e_stall));
    chk({tag, " R7 active"}, 32'(vp_active), 32'(e_act));
    chk({tag, " R8 has_work"}, 32'(has_work), 32'(e_hw));
    chk({tag, " R8 run_en"}, 32'(run_en), 32'(e_run));
    chk({tag, " R11 read"}, cop_rd_data, e_rd);
    for (int i = 0; i < N; i++) begin
      n_dis[i] = m_dis[i];
      n_slp[i] = m_sleep[i] && !e_hw[i];
    end
    if (g >= 0) begin
      prior = m_dis[g];
      e_wbv[g] = 1'b1;
      if (is_s && !prior) begin
        n_dis[g] = 1;
        for (int j = 0; j < N; j++) if (j != g) n_slp[j] = 1;
      end
      if (is_r && prior) begin
        n_dis[g] = 0;
        for (int j = 0; j < N; j++) if (j != g && !wfi_halt[j]) n_slp[j] = 0;
      end
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin m_dis[i] = n_dis[i]; m_sleep[i] = n_slp[i]; end
    @(negedge clk);
    chk({tag, " R6 wb_vld"}, 32'(wb_vld), 32'(e_wbv));
    if (g >= 0) begin
      chk({tag, " R6 wb_idx"}, 32'(wb_idx[g]), 32'(rt));
      chk({tag, " R6 wb_data"}, wb_data[g], {31'd0, prior});
    end
  endtask

  task automatic idle();
    ins_vld = '0;
    ins_word = '0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; feature_en = 1; idle(); wfi_halt = '0; wake_req = '0;
    cop_rd_vp = '0; cop_rd_sel = '0; cop_wr_en = 0; cop_wr_vp = '0;
    cop_wr_sel = '0; cop_wr_data = '0;
    for (int i = 0; i < N; i++) begin m_dis[i] = 0; m_sleep[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 run_en", 32'(run_en), 32'hF);
    chk("R12 wb_vld", 32'(wb_vld), 0);
    chk("R12 ctl read", cop_rd_data, 0);

    // R11 identity words
    for (int v = 0; v < N; v++) begin
      cop_rd_vp = IW'(v); cop_rd_sel = 3'd1;
      step("R11 id");
      chk("R11 id value", cop_rd_data, 32'(v));
    end
    cop_rd_sel = 3'd5; step("R11 bad sel");
    cop_rd_sel = 3'd0;

    // R1 near-miss word ignored
    ins_vld[2] = 1; ins_word[2] = 32'h41600025; step("R1 miss");
    ins_word[2] = 32'h41610004 | 32'h00000100; step("R1 miss2");
    idle();

    // R2 suspend from VP1, rt 7
    cop_rd_vp = 1;
    ins_vld[1] = 1; ins_word[1] = susp_w(7); step("R2 susp");
    idle(); step("R2 after");
    chk("R2 only issuer runs", 32'(run_en), 32'b0010);
    chk("R2 flag read", cop_rd_data, 1);

    // R3 repeat suspend, R7/R8 wake on suspended peer hidden
    wake_req[2] = 1;
    ins_vld[1] = 1; ins_word[1] = susp_w(3); step("R3 susp again");
    chk("R3 prior value", wb_data[1], 1);
    idle(); step("R8 hidden wake");
    chk("R8 peer no work", 32'(has_work[2]), 0);
    wake_req[2] = 0;

    // R4 resume with VP3 parked
    wfi_halt[3] = 1;
    ins_vld[1] = 1; ins_word[1] = resm_w(9); step("R4 resm");
    idle(); wfi_halt[3] = 0; step("R4 parked");
    chk("R4 parked stays off", 32'(run_en[3]), 0);
    chk("R4 others run", 32'(run_en), 32'b0111);
    wake_req[3] = 1; step("R8 wake parked");
    wake_req[3] = 0; step("R8 woke");
    chk("R8 parked runs", 32'(run_en[3]), 1);

    // R5 resume with flag clear
    ins_vld[0] = 1; ins_word[0] = resm_w(31); step("R5 resm noop");
    chk("R5 prior zero", wb_data[0], 0);
    idle();

    // R9 contention: VP0 and VP2 suspend together
    ins_vld[0] = 1; ins_word[0] = susp_w(4);
    ins_vld[2] = 1; ins_word[2] = susp_w(5); step("R9 clash");
    chk("R9 loser no wb", 32'(wb_vld[2]), 0);
    idle(); step("R9 idle");
    ins_vld[0] = 1; ins_word[0] = resm_w(1); step("R9 release");
    idle();
    ins_vld[2] = 1; ins_word[2] = resm_w(2);
    ins_vld[3] = 1; ins_word[3] = resm_w(6); step("R9 clash2");
    ins_vld[2] = 0; step("R9 second served");
    idle(); step("R9 idle2");

    // R11 writes discarded
    cop_wr_en = 1; cop_wr_vp = 0; cop_wr_sel = 0; cop_wr_data = 32'h1;
    cop_rd_vp = 0; step("R11 wr ctl");
    cop_wr_sel = 1; cop_wr_data = 32'hAB; cop_rd_sel = 1; step("R11 wr id");
    cop_wr_en = 0; step("R11 after wr");
    chk("R11 id unchanged", cop_rd_data, 0);
    cop_rd_sel = 0;

    // R10 feature off
    feature_en = 0; wake_req = 4'b1010;
    ins_vld[1] = 1; ins_word[1] = susp_w(8);
    ins_vld[0] = 1; ins_word[0] = susp_w(8); step("R10 off");
    idle(); step("R10 off2");
    chk("R10 no suspend", 32'(run_en), 32'hF);
    wake_req = '0; feature_en = 1; step("R10 back on");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule